// File: doc/BRIEF.md
# Four-Step Signed Word Dot-Product Accumulator

This execution unit folds eight signed 16-bit products into each of sixteen 32-bit accumulator lanes. It runs over four clock steps. A single accepted `start` captures four things: the destination vector, a 128-bit multiplier operand, the per-lane write mask and the mode bits. The unit then walks through an aligned group of four source vectors. In each step it presents a register index on `rd_idx` and consumes the vector returned on `rd_data` in that same cycle.

In step m, each lane takes its own pair of source words. It multiplies them element-wise by the two halves of dword m of the multiplier operand and adds both products to its running sum. The unit writes the finished vector to `result` in a single update, and `done` pulses in the same cycle.

The per-lane mask decides what each lane ends with. A selected lane ends with its sum. An unselected lane is either cleared or restored from the snapshot of the destination taken at start.

A request for the multiplier operand is signalled combinationally. Two encoding conditions reject the operation outright: the broadcast control bit, and an addressing-mode field of all ones.

Top module: `wdot4_unit`

## Requirements
- R1: After a start is accepted, `busy` is 1 for exactly four cycles. `done` is 1 for the single cycle that follows. `result` changes only at the clock edge that raises `done`.
- R2: During busy cycle m (m = 0..3), `rd_idx` equals the captured `src_idx` with its two low bits cleared, plus m.
- R3: In step m, lane i (bits 32i+31..32i) adds two products to its sum: signed word 2i of `rd_data` times signed bits 32m+15..32m of `op2_in`, and signed word 2i+1 times signed bits 32m+31..32m+16. The sum starts at lane i of `dst_in`.
- R4: Each product is a full signed 32-bit value. Lane sums wrap modulo 2^32 with no saturation.
- R5: A lane ends with its sum when `mask_en` is 0, or when its bit in `mask_in` (bit i for lane i) is 1.
- R6: An unselected lane ends as zero when `zero_mode` was 1 at start.
- R7: An unselected lane with `zero_mode` 0 ends with its `dst_in` value as captured at start. Later changes to `dst_in` do not affect it.
- R8: `load_req` is 1 when `mask_en` is 0 or when any bit of `mask_in` is 1, and 0 otherwise.
- R9: A start with `bcast_bit` = 1 or `mod_field` = 2'b11 raises `illegal` for the next cycle only. It does not raise `busy` and leaves `result` unchanged.
- R10: `start` while `busy` is 1 is ignored. The running operation keeps its index sequence and its result.
- R11: During and right after reset, `busy`, `done` and `illegal` are 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| src_idx | input | 5 | Register index naming the source group |
| dst_in | input | 512 | Original destination vector |
| op2_in | input | 128 | Four 32-bit multiplier pairs |
| mask_in | input | 16 | Per-lane write mask |
| mask_en | input | 1 | 1 when the write mask is in use |
| zero_mode | input | 1 | 1 clears unselected lanes, 0 keeps them |
| bcast_bit | input | 1 | Broadcast control bit (illegal when 1) |
| mod_field | input | 2 | Addressing-mode field (illegal when 2'b11) |
| rd_idx | output | 5 | Source register index for the current step |
| rd_data | input | 512 | Source vector read at `rd_idx` |
| load_req | output | 1 | Multiplier operand is needed |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse with the new result |
| illegal | output | 1 | One-cycle pulse for a rejected encoding |
| result | output | 512 | Final accumulated vector |

## Verification
A start is captured at edge 0. `rd_idx` shows step m after edge m, for m from 0 to 3. `done` and the new `result` appear after edge 4, and `illegal` appears after edge 0.

The bench drives every input on the falling edge and samples on the following falling edges. It therefore checks `busy` and `rd_idx` once per step, `done` and `result` exactly four cycles after the start cycle, and the absence of `done` one cycle later. `load_req` is combinational and is checked a short delay after the mask inputs change.

// File: rtl/wdot4_pkg.sv
package wdot4_pkg;

  // Signed dot product of one word pair with one multiplier pair, 32-bit wrap.
  function automatic logic [31:0] pair_dot(input logic [31:0] words, input logic [31:0] mult);
    logic signed [31:0] lo_p;
    logic signed [31:0] hi_p;
    lo_p = 32'($signed(words[15:0]))  * 32'($signed(mult[15:0]));
    hi_p = 32'($signed(words[31:16])) * 32'($signed(mult[31:16]));
    return lo_p + hi_p;
  endfunction

  // Final lane choice: sum, cleared, or restored snapshot.
  function automatic logic [31:0] lane_pick(input logic [31:0] sum, input logic [31:0] orig,
                                            input logic sel, input logic clr);
    if (sel)      return sum;
    else if (clr) return 32'd0;
    else          return orig;
  endfunction

endpackage

// File: rtl/wdot4_ctrl.sv
module wdot4_ctrl #(
  parameter int STEPS = 4,
  localparam int SW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bad_enc,
  output logic          go,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          last_step,
  output logic          done,
  output logic          illegal
);
  logic accept;

  assign accept    = start && !busy;
  assign go        = accept && !bad_enc;
  assign last_step = busy && (step == SW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      step    <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= last_step;
      illegal <= accept && bad_enc;
      if (go) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (last_step) busy <= 1'b0;
        else           step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdot4_idx.sv
module wdot4_idx #(
  parameter int IDXW  = 5,
  parameter int STEPS = 4,
  localparam int SW = $clog2(STEPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IDXW-1:0] idx_in,
  input  logic [SW-1:0]   step,
  output logic [IDXW-1:0] rd_idx
);
  localparam logic [IDXW-1:0] LOW_CLR = ~IDXW'(STEPS - 1);
  logic [IDXW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= idx_in & LOW_CLR;
  end

  assign rd_idx = base_q | IDXW'(step);
endmodule

// File: rtl/wdot4_lanes.sv
module wdot4_lanes
  import wdot4_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VECW = LANES * 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step_en,
  input  logic [VECW-1:0] dst_in,
  input  logic [VECW-1:0] src_vec,
  input  logic [31:0]     mult,
  output logic [VECW-1:0] acc_nx
);
  logic [VECW-1:0] acc_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign acc_nx[i*32 +: 32] = acc_q[i*32 +: 32] + pair_dot(src_vec[i*32 +: 32], mult);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (load)    acc_q <= dst_in;
    else if (step_en) acc_q <= acc_nx;
  end
endmodule

// File: rtl/wdot4_unit.sv
module wdot4_unit
  import wdot4_pkg::*;
#(
  parameter int LANES = 16,
  parameter int STEPS = 4,
  parameter int IDXW  = 5,
  localparam int VECW = LANES * 32,
  localparam int OPW  = STEPS * 32,
  localparam int SW   = $clog2(STEPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDXW-1:0] src_idx,
  input  logic [VECW-1:0] dst_in,
  input  logic [OPW-1:0]  op2_in,
  input  logic [LANES-1:0] mask_in,
  input  logic            mask_en,
  input  logic            zero_mode,
  input  logic            bcast_bit,
  input  logic [1:0]      mod_field,
  output logic [IDXW-1:0] rd_idx,
  input  logic [VECW-1:0] rd_data,
  output logic            load_req,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [VECW-1:0] result
);
  logic            bad_enc;
  logic            go;
  logic [SW-1:0]   step;
  logic            last_step;
  logic [VECW-1:0] acc_nx;
  logic [VECW-1:0] fin;
  logic [31:0]     mult;

  logic [VECW-1:0]  orig_q;
  logic [OPW-1:0]   op2_q;
  logic [LANES-1:0] sel_q;
  logic             clr_q;

  assign bad_enc  = bcast_bit || (mod_field == 2'b11);
  assign load_req = !mask_en || (|mask_in);
  assign mult     = op2_q[{step, 5'd0} +: 32];

  wdot4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bad_enc(bad_enc), .go(go),
    .busy(busy), .step(step), .last_step(last_step), .done(done), .illegal(illegal)
  );

  wdot4_idx #(.IDXW(IDXW), .STEPS(STEPS)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(go), .idx_in(src_idx), .step(step), .rd_idx(rd_idx)
  );

  wdot4_lanes #(.LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load(go), .step_en(busy), .dst_in(dst_in),
    .src_vec(rd_data), .mult(mult), .acc_nx(acc_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_q <= '0;
      op2_q  <= '0;
      sel_q  <= '0;
      clr_q  <= 1'b0;
    end else if (go) begin
      orig_q <= dst_in;
      op2_q  <= op2_in;
      sel_q  <= mask_en ? mask_in : '1;
      clr_q  <= zero_mode;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_pick
    assign fin[i*32 +: 32] = lane_pick(acc_nx[i*32 +: 32], orig_q[i*32 +: 32], sel_q[i], clr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result <= '0;
    else if (last_step) result <= fin;
  end
endmodule

// File: rtl/wdot4_chk.sv
module wdot4_chk #(
  parameter int VECW  = 512,
  parameter int IDXW  = 5,
  parameter int STEPS = 4,
  localparam int SW = $clog2(STEPS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            illegal,
  input logic [SW-1:0]   step,
  input logic [IDXW-1:0] rd_idx,
  input logic [VECW-1:0] result,
  input logic            load_req,
  input logic            mask_en,
  input logic [15:0]     mask_in,
  input logic            bcast_bit,
  input logic [1:0]      mod_field
);
  a_r1_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == SW'(STEPS - 1)) |=> (done && !busy));
  a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != SW'(STEPS - 1)) |=> busy);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_result_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_idx[SW-1:0] == step));
  a_r8_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && mask_in == 16'd0) |-> !load_req);
  a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (bcast_bit || mod_field == 2'b11)) |=> (illegal && !busy));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && step != SW'(STEPS - 1)) |=> (step == SW'($past(step) + 1'b1)));
endmodule

bind wdot4_unit wdot4_chk #(.VECW(VECW), .IDXW(IDXW), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .illegal(illegal),
  .step(step), .rd_idx(rd_idx), .result(result), .load_req(load_req), .mask_en(mask_en),
  .mask_in(mask_in), .bcast_bit(bcast_bit), .mod_field(mod_field)
);

// File: tb/wdot4_unit_tb.sv
module wdot4_unit_tb;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [4:0]   src_idx = '0;
  logic [511:0] dst_in = '0;
  logic [127:0] op2_in = '0;
  logic [15:0]  mask_in = '0;
  logic         mask_en = 1'b0;
  logic         zero_mode = 1'b0;
  logic         bcast_bit = 1'b0;
  logic [1:0]   mod_field = 2'b00;
  logic [4:0]   rd_idx;
  logic [511:0] rd_data;
  logic         load_req, busy, done, illegal;
  logic [511:0] result;

  logic [511:0] regs [32];
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rd_data = regs[rd_idx];

  wdot4_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_idx(src_idx), .dst_in(dst_in),
    .op2_in(op2_in), .mask_in(mask_in), .mask_en(mask_en), .zero_mode(zero_mode),
    .bcast_bit(bcast_bit), .mod_field(mod_field), .rd_idx(rd_idx), .rd_data(rd_data),
    .load_req(load_req), .busy(busy), .done(done), .illegal(illegal), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference: eight signed products per lane, then mask choice.
  function automatic logic [511:0] model(input logic [511:0] d, input logic [127:0] o,
      input logic [4:0] idx, input logic [15:0] m, input bit men, input bit zm);
    logic [511:0] r;
    logic [4:0] b;
    b = {idx[4:2], 2'b00};
    for (int i = 0; i < 16; i++) begin
      logic [31:0] s;
      s = d[i*32 +: 32];
      for (int st = 0; st < 4; st++) begin
        logic [511:0] v;
        logic [31:0] t;
        v = regs[b + 5'(st)];
        t = o[st*32 +: 32];
        s = s + 32'(int'($signed(v[i*32 +: 16])) * int'($signed(t[15:0])))
              + 32'(int'($signed(v[i*32+16 +: 16])) * int'($signed(t[31:16])));
      end
      if (!men || m[i]) r[i*32 +: 32] = s;
      else if (zm)      r[i*32 +: 32] = 32'd0;
      else              r[i*32 +: 32] = d[i*32 +: 32];
    end
    return r;
  endfunction

  task automatic run_op(input logic [4:0] idx, input logic [511:0] d, input logic [127:0] o,
      input logic [15:0] m, input bit men, input bit zm, input bit poke, input string tag);
    logic [511:0] exp;
    logic [4:0] b;
    exp = model(d, o, idx, m, men, zm);
    b = {idx[4:2], 2'b00};
    src_idx = idx; dst_in = d; op2_in = o; mask_in = m; mask_en = men; zero_mode = zm;
    bcast_bit = 1'b0; mod_field = 2'b00; start = 1'b1;
    for (int st = 0; st < 4; st++) begin
      @(negedge clk);
      start = 1'b0;
      dst_in = rnd512();   // R7: later destination changes must not matter
      if (poke && st == 1) begin start = 1'b1; src_idx = ~idx; end  // R10
      chk(busy === 1'b1 && done === 1'b0, "R1 busy", {511'd0, busy}, 512'd1);
      chk(rd_idx === b + 5'(st), "R2 rd_idx", {507'd0, rd_idx}, {507'd0, b + 5'(st)});
    end
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R1 done", {511'd0, done}, 512'd1);
    chk(result === exp, tag, result, exp);
    @(negedge clk);
    chk(done === 1'b0, "R1 done pulse", {511'd0, done}, 512'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] prev;
    void'($urandom(32'd1234));
    for (int r = 0; r < 32; r++) regs[r] = rnd512();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 0 && done === 0 && illegal === 0 && result === '0, "R11 reset", result, 512'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && result === '0, "R11 after reset", result, 512'd0);

    // R8 load request
    mask_en = 1'b1; mask_in = 16'h0000; #1;
    chk(load_req === 1'b0, "R8 no bits", {511'd0, load_req}, 512'd0);
    mask_in = 16'h0100; #1;
    chk(load_req === 1'b1, "R8 one bit", {511'd0, load_req}, 512'd1);
    mask_en = 1'b0; mask_in = 16'h0000; #1;
    chk(load_req === 1'b1, "R8 unmasked", {511'd0, load_req}, 512'd1);
    @(negedge clk);

    // Directed: R3 simple, R4 wrap, R5/R6/R7 masks
    run_op(5'd6, rnd512(), 128'h0004_0003_0002_0001_ffff_0001_0001_0001, 16'h0, 1'b0, 1'b0, 1'b0, "R3 unmasked");
    for (int r = 4; r < 8; r++) regs[r] = {32{16'h8000}};
    run_op(5'd5, {16{32'h7fff_ffff}}, {8{16'h8000}}, 16'h0, 1'b0, 1'b0, 1'b0, "R4 wrap");
    run_op(5'd7, {16{32'h1234_5678}}, {8{16'h7fff}}, 16'h5a5a, 1'b1, 1'b1, 1'b0, "R6 zeroing");
    run_op(5'd2, rnd512(), rnd512()[127:0], 16'hc003, 1'b1, 1'b0, 1'b0, "R7 merge");
    run_op(5'd31, rnd512(), rnd512()[127:0], 16'hffff, 1'b1, 1'b0, 1'b1, "R10 restart ignored");
    run_op(5'd9, rnd512(), rnd512()[127:0], 16'h0000, 1'b1, 1'b0, 1'b0, "R7 none selected");
    for (int r = 0; r < 32; r++) regs[r] = rnd512();

    // R9 illegal encodings
    for (int c = 0; c < 2; c++) begin
      prev = result;
      src_idx = 5'd3; dst_in = rnd512(); start = 1'b1;
      bcast_bit = (c == 0); mod_field = (c == 0) ? 2'b00 : 2'b11;
      @(negedge clk);
      start = 1'b0; bcast_bit = 1'b0; mod_field = 2'b00;
      chk(illegal === 1'b1 && busy === 1'b0, "R9 flag", {511'd0, illegal}, 512'd1);
      @(negedge clk);
      chk(illegal === 1'b0 && busy === 1'b0 && done === 1'b0, "R9 pulse", {511'd0, illegal}, 512'd0);
      chk(result === prev, "R9 result kept", result, prev);
    end

    // Random: R3 R5 R6 R7 mixes
    for (int n = 0; n < 40; n++) begin
      run_op(5'($urandom), rnd512(), rnd512()[127:0], 16'($urandom), 1'($urandom),
             1'($urandom), (n % 5) == 0, "R5 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule